// File: doc/BRIEF.md
# Shared-Bus Accumulator Processor Core

A 16-bit accumulator processor core in which every register transfer crosses one internal data bus. A 3-bit source code picks the register or the memory word that drives the bus. A sequence counter steps each instruction through fixed timing phases, and a decoder turns the count into one-hot phase strobes. Each instruction is fetched, decoded, optionally resolved through one level of indirection, and then executed. The core runs the seven memory-reference operations itself. For opcode 7 it sends the decoded instruction to companion units through two strobes and the low instruction field. Those units handle the register operations and the device operations.

The word store sits next to the core. The core presents the address register as the memory address and the bus value as the write data. It issues a write strobe and reads the addressed word combinationally. The run flip-flop starts set after reset. It clears on a stop request and then freezes the sequence counter and all register updates.

Instruction word: bit 15 is the indirect flag, bits 14..12 hold the opcode, and bits 11..0 hold the operand address. The opcodes are 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ and 7 for the companion units.

Top module: `acc_cpu`

## Requirements
- R1: After reset the following hold: PC = 0, the phase count = 0, AC = 0, E = 0 and the run flag = 1.
- R2: The phase count advances by one per clock while running. During the T0 phase the bus carries PC and AR loads it. During the T1 phase IR loads the memory word and PC increments by one. During the T2 phase AR loads IR[11:0] and the indirect flag loads IR[15].
- R3: The bus source codes are 0 = none (the bus reads zero), 1 = AR, 2 = PC, 3 = DR, 4 = AC, 5 = IR, 6 = TR and 7 = memory word. The fetch phases T0, T1 and T2 use codes 2, 7 and 5 in that order.
- R4: AND takes 6 cycles and leaves AC = AC & M[addr].
- R5: ADD takes 6 cycles and leaves AC = (AC + M[addr]) mod 2^16, with E set to the carry out of bit 15.
- R6: LDA takes 6 cycles and leaves AC = M[addr]. With bit 15 set, the T3 phase (bus code 7) replaces the address with M[addr], so AC = M[M[addr]] and the cycle count stays the same.
- R7: STA takes 5 cycles. During the T4 phase, with bus code 4, it writes AC to M[addr].
- R8: BUN takes 5 cycles. During the T4 phase, with bus code 1, it loads PC with the address.
- R9: BSA takes 6 cycles. It writes the return address (the incremented PC) to M[addr] and leaves PC = addr + 1.
- R10: ISZ takes 7 cycles and writes M[addr] + 1 back to memory during the T6 phase with bus code 3. When that sum is zero, PC gets one extra increment.
- R11: Opcode 7 ends after 4 cycles. During the T3 phase it pulses the register strobe (bit 15 = 0) or the device strobe (bit 15 = 1) for one cycle, with IR[11:0] on the operation field.
- R12: A stop request clears the run flag at the next edge. From then on the phase count and PC hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_i | input | 1 | Stop request; clears the run flag |
| mem_rdata_i | input | 16 | Word read at mem_addr_o |
| mem_addr_o | output | 12 | Memory address (AR) |
| mem_wdata_o | output | 16 | Write data (bus value) |
| mem_we_o | output | 1 | Memory write strobe |
| rr_exec_o | output | 1 | Register-operation strobe (T3) |
| io_exec_o | output | 1 | Device-operation strobe (T3) |
| ext_bits_o | output | 12 | IR[11:0] for the companion units |
| run_o | output | 1 | Run flag |
| t_o | output | 4 | Phase count |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flip-flop E |
| bus_sel_o | output | 3 | Current bus source code |
| bus_o | output | 16 | Current bus value |

## Verification
After reset is released, the first clock edge executes phase T0. A result is therefore due at the edge that closes the instruction's last phase: 4 cycles for opcode 7, 5 for STA and BUN, 6 for AND, ADD, LDA and BSA, and 7 for ISZ. Instructions placed back to back add up their counts. The bench counts exactly those edges after reset and samples on the following falling edge. It reads phase-specific bus codes and strobes on the falling edge inside the phase, before the edge that closes it. For a stop, the bench checks that the phase count and PC hold for twenty cycles after the single edge that clears the run flag.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_AR   = 3'd1,
      SRC_PC   = 3'd2,
      SRC_DR   = 3'd3,
      SRC_AC   = 3'd4,
      SRC_IR   = 3'd5,
      SRC_TR   = 3'd6,
      SRC_MEM  = 3'd7
   } bus_src_e;

   localparam int unsigned OPC_AND = 0;
   localparam int unsigned OPC_ADD = 1;
   localparam int unsigned OPC_LDA = 2;
   localparam int unsigned OPC_STA = 3;
   localparam int unsigned OPC_BUN = 4;
   localparam int unsigned OPC_BSA = 5;
   localparam int unsigned OPC_ISZ = 6;
   localparam int unsigned OPC_EXT = 7;
endpackage

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
   parameter int unsigned SC_W = 4,
   localparam int unsigned NT = 1 << SC_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            clr,
   output logic [SC_W-1:0] count,
   output logic [NT-1:0]   phase
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (run)
         count <= clr ? '0 : count + 1'b1;
   end

   for (genvar i = 0; i < NT; i++) begin : g_phase
      assign phase[i] = (count == SC_W'(i));
   end
endmodule

// File: rtl/acc_op_decoder.sv
module acc_op_decoder #(
   parameter int unsigned OP_W = 3,
   localparam int unsigned NOPS = 1 << OP_W
) (
   input  logic [OP_W-1:0] opcode,
   output logic [NOPS-1:0] dec
);
   for (genvar i = 0; i < NOPS; i++) begin : g_dec
      assign dec[i] = (opcode == OP_W'(i));
   end
endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SEL_W  = 3,
   localparam int unsigned NSRC = 1 << SEL_W
) (
   input  logic [NSRC-1:0][DATA_W-1:0] srcs,
   input  logic [SEL_W-1:0]            sel,
   output logic [DATA_W-1:0]           bus
);
   logic [NSRC-1:0][DATA_W-1:0] gated;

   // code 0 is the idle code and never reaches the bus
   assign gated[0] = '0;
   for (genvar i = 1; i < NSRC; i++) begin : g_src
      assign gated[i] = srcs[i] & {DATA_W{sel == SEL_W'(i)}};
   end

   always_comb begin
      bus = '0;
      for (int k = 0; k < NSRC; k++) bus = bus | gated[k];
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int unsigned DATA_W = 16,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] ac,
   input  logic [DATA_W-1:0] dr,
   input  logic              e_in,
   input  logic              do_and,
   input  logic              do_add,
   output logic [DATA_W-1:0] ac_next,
   output logic              e_next
);
   logic [DATA_W-1:0] sum;
   logic              cout;

   if (RIPPLE) begin : g_ripple
      logic [DATA_W:0] c;
      assign c[0] = 1'b0;
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign sum[b] = ac[b] ^ dr[b] ^ c[b];
         assign c[b+1] = (ac[b] & dr[b]) | (c[b] & (ac[b] ^ dr[b]));
      end
      assign cout = c[DATA_W];
   end else begin : g_behav
      assign {cout, sum} = {1'b0, ac} + {1'b0, dr};
   end

   always_comb begin
      ac_next = dr;
      e_next  = e_in;
      if (do_and) begin
         ac_next = ac & dr;
      end else if (do_add) begin
         ac_next = sum;
         e_next  = cout;
      end
   end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned OP_W   = 3,
   parameter int unsigned SC_W   = 4,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_we_o,
   output logic              rr_exec_o,
   output logic              io_exec_o,
   output logic [ADDR_W-1:0] ext_bits_o,
   output logic              run_o,
   output logic [SC_W-1:0]   t_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] ac_o,
   output logic              e_o,
   output logic [2:0]        bus_sel_o,
   output logic [DATA_W-1:0] bus_o
);
   localparam int unsigned NT   = 1 << SC_W;
   localparam int unsigned NOPS = 1 << OP_W;
   localparam int unsigned IND_BIT = DATA_W - 1;

   if (DATA_W != ADDR_W + OP_W + 1) begin : g_bad_word
      $error("instruction word must be flag + opcode + address");
   end
   if (NT < 7) begin : g_bad_sc
      $error("phase counter must reach T6");
   end
   if (NOPS != 8) begin : g_bad_op
      $error("opcode field must decode to eight operations");
   end

   logic [ADDR_W-1:0] ar_q, pc_q;
   logic [DATA_W-1:0] dr_q, ac_q, ir_q;
   logic              e_q, ind_q, run_q;

   logic [SC_W-1:0]   count;
   logic [NT-1:0]     ph;
   logic [NOPS-1:0]   d;
   logic [DATA_W-1:0] bus;
   logic [DATA_W-1:0] alu_ac;
   logic              alu_e;
   bus_src_e          sel;

   logic ar_ld, ar_inc, pc_ld, pc_inc, dr_ld, dr_inc;
   logic ac_ld, ir_ld, ind_ld, we, sc_clr, rr_go, io_go;

   acc_seq_timer #(.SC_W(SC_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run_q), .clr(sc_clr),
      .count(count), .phase(ph)
   );

   acc_op_decoder #(.OP_W(OP_W)) u_dec (
      .opcode(ir_q[DATA_W-2 -: OP_W]), .dec(d)
   );

   logic [7:0][DATA_W-1:0] srcs;
   assign srcs[SRC_NONE] = '0;
   assign srcs[SRC_AR]   = DATA_W'(ar_q);
   assign srcs[SRC_PC]   = DATA_W'(pc_q);
   assign srcs[SRC_DR]   = dr_q;
   assign srcs[SRC_AC]   = ac_q;
   assign srcs[SRC_IR]   = ir_q;
   // the temporary register is loaded only by the interrupt path, held at zero here
   assign srcs[SRC_TR]   = '0;
   assign srcs[SRC_MEM]  = mem_rdata_i;

   acc_bus_mux #(.DATA_W(DATA_W), .SEL_W(3)) u_bus (
      .srcs(srcs), .sel(sel), .bus(bus)
   );

   acc_alu #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_alu (
      .ac(ac_q), .dr(dr_q), .e_in(e_q),
      .do_and(d[OPC_AND]), .do_add(d[OPC_ADD]),
      .ac_next(alu_ac), .e_next(alu_e)
   );

   wire unused_phase = ^ph[NT-1:7];

   always_comb begin
      sel = SRC_NONE;
      ar_ld = 1'b0;  ar_inc = 1'b0;  pc_ld = 1'b0;  pc_inc = 1'b0;
      dr_ld = 1'b0;  dr_inc = 1'b0;  ac_ld = 1'b0;  ir_ld  = 1'b0;
      ind_ld = 1'b0; we = 1'b0;      sc_clr = 1'b0;
      rr_go = 1'b0;  io_go = 1'b0;
      if (run_q) begin
         if (ph[0]) begin
            sel = SRC_PC;  ar_ld = 1'b1;
         end
         if (ph[1]) begin
            sel = SRC_MEM; ir_ld = 1'b1; pc_inc = 1'b1;
         end
         if (ph[2]) begin
            sel = SRC_IR;  ar_ld = 1'b1; ind_ld = 1'b1;
         end
         if (ph[3]) begin
            if (d[OPC_EXT]) begin
               sc_clr = 1'b1;
               rr_go  = ~ind_q;
               io_go  = ind_q;
            end else if (ind_q) begin
               sel = SRC_MEM; ar_ld = 1'b1;
            end
         end
         if (ph[4]) begin
            if (d[OPC_AND] | d[OPC_ADD] | d[OPC_LDA] | d[OPC_ISZ]) begin
               sel = SRC_MEM; dr_ld = 1'b1;
            end
            if (d[OPC_STA]) begin
               sel = SRC_AC; we = 1'b1; sc_clr = 1'b1;
            end
            if (d[OPC_BUN]) begin
               sel = SRC_AR; pc_ld = 1'b1; sc_clr = 1'b1;
            end
            if (d[OPC_BSA]) begin
               sel = SRC_PC; we = 1'b1; ar_inc = 1'b1;
            end
         end
         if (ph[5]) begin
            if (d[OPC_AND] | d[OPC_ADD] | d[OPC_LDA]) begin
               ac_ld = 1'b1; sc_clr = 1'b1;
            end
            if (d[OPC_BSA]) begin
               sel = SRC_AR; pc_ld = 1'b1; sc_clr = 1'b1;
            end
            if (d[OPC_ISZ]) dr_inc = 1'b1;
         end
         if (ph[6] && d[OPC_ISZ]) begin
            sel = SRC_DR; we = 1'b1; sc_clr = 1'b1;
            pc_inc = (dr_q == '0);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ar_q <= '0; pc_q <= '0; dr_q <= '0; ac_q <= '0;
         ir_q <= '0; e_q <= 1'b0; ind_q <= 1'b0; run_q <= 1'b1;
      end else begin
         if (stop_i) run_q <= 1'b0;
         if (ar_ld)       ar_q <= bus[ADDR_W-1:0];
         else if (ar_inc) ar_q <= ar_q + 1'b1;
         if (pc_ld)       pc_q <= bus[ADDR_W-1:0];
         else if (pc_inc) pc_q <= pc_q + 1'b1;
         if (dr_ld)       dr_q <= bus;
         else if (dr_inc) dr_q <= dr_q + 1'b1;
         if (ac_ld) begin
            ac_q <= alu_ac;
            e_q  <= alu_e;
         end
         if (ir_ld)  ir_q  <= bus;
         if (ind_ld) ind_q <= bus[IND_BIT];
      end
   end

   assign mem_addr_o  = ar_q;
   assign mem_wdata_o = bus;
   assign mem_we_o    = we;
   assign rr_exec_o   = rr_go;
   assign io_exec_o   = io_go;
   assign ext_bits_o  = ir_q[ADDR_W-1:0];
   assign run_o       = run_q;
   assign t_o         = count;
   assign pc_o        = pc_q;
   assign ac_o        = ac_q;
   assign e_o         = e_q;
   assign bus_sel_o   = sel;
   assign bus_o       = bus;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned SC_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_i,
   input logic              run_o,
   input logic [SC_W-1:0]   t_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic [2:0]        bus_sel_o,
   input logic [DATA_W-1:0] bus_o,
   input logic              mem_we_o,
   input logic              rr_exec_o,
   input logic              io_exec_o
);
   // R3
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel_o == 3'd0) |-> (bus_o == '0));

   // R2
   fetch_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && t_o == SC_W'(1)) |=> (pc_o == $past(pc_o) + 1'b1));

   // R12
   stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !run_o);

   // R12
   halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |=> ($stable(t_o) && $stable(pc_o)));

   // R11
   ext_strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rr_exec_o, io_exec_o}));

   // R11
   ext_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_exec_o || io_exec_o) |=> (t_o == '0));

   // R7
   write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (t_o == SC_W'(4) || t_o == SC_W'(6)));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SC_W(SC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .run_o(run_o), .t_o(t_o),
   .pc_o(pc_o), .bus_sel_o(bus_sel_o), .bus_o(bus_o), .mem_we_o(mem_we_o),
   .rr_exec_o(rr_exec_o), .io_exec_o(io_exec_o)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stop_i = 1'b0;
   logic [15:0] mem_rdata;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we, rr_exec, io_exec, run, e;
   logic [11:0] ext_bits, pc;
   logic [3:0]  t;
   logic [15:0] ac, bus;
   logic [2:0]  bus_sel;

   logic [15:0] mem [256];

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

   acc_cpu uut (
      .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .mem_rdata_i(mem_rdata),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
      .rr_exec_o(rr_exec), .io_exec_o(io_exec), .ext_bits_o(ext_bits),
      .run_o(run), .t_o(t), .pc_o(pc), .ac_o(ac), .e_o(e),
      .bus_sel_o(bus_sel), .bus_o(bus)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
   endtask

   // reset, then leave the bench on a falling edge just before posedge 1 (T0)
   task automatic restart();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic run_cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 reset state and R3 fetch bus codes
      clear_mem();
      mem[0] = 16'h2020; mem[8'h20] = 16'h1357;
      restart();
      chk("R1 pc", {4'h0, pc}, 16'h0000);
      chk("R1 t", {12'h0, t}, 16'h0000);
      chk("R1 ac", ac, 16'h0000);
      chk("R1 e", {15'h0, e}, 16'h0000);
      chk("R1 run", {15'h0, run}, 16'h0001);
      chk("R3 T0 sel", {13'h0, bus_sel}, 16'h0002);
      chk("R2 T0 bus=pc", bus, 16'h0000);
      run_cycles(1);
      chk("R3 T1 sel", {13'h0, bus_sel}, 16'h0007);
      chk("R2 T1 bus=mem", bus, 16'h2020);
      run_cycles(1);
      chk("R3 T2 sel", {13'h0, bus_sel}, 16'h0005);
      chk("R2 pc after fetch", {4'h0, pc}, 16'h0001);
      run_cycles(4);
      chk("R6 lda ac", ac, 16'h1357);
      chk("R6 lda t", {12'h0, t}, 16'h0000);

      // R5 ADD sweep and R4 AND sweep
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            logic [15:0] a, b;
            logic [16:0] s;
            a = 16'((i * 16'h2493) ^ (i == 7 ? 16'hFFFF : 16'h0));
            b = 16'((j * 16'h3A1D) + (j == 5 ? 16'h8000 : 16'h0));
            s = {1'b0, a} + {1'b0, b};
            clear_mem();
            mem[0] = 16'h2020; mem[1] = 16'h1021;
            mem[8'h20] = a; mem[8'h21] = b;
            restart();
            run_cycles(12);
            chk("R5 add sum", ac, s[15:0]);
            chk("R5 add carry", {15'h0, e}, {15'h0, s[16]});
            clear_mem();
            mem[0] = 16'h2020; mem[1] = 16'h0021;
            mem[8'h20] = a; mem[8'h21] = b;
            restart();
            run_cycles(12);
            chk("R4 and", ac, a & b);
            chk("R4 and pc", {4'h0, pc}, 16'h0002);
         end
      end

      // R6 indirect LDA
      clear_mem();
      mem[0] = 16'hA030; mem[8'h30] = 16'h0045; mem[8'h45] = 16'h1234;
      restart();
      run_cycles(3);
      chk("R6 T3 indirect sel", {13'h0, bus_sel}, 16'h0007);
      run_cycles(3);
      chk("R6 indirect ac", ac, 16'h1234);
      chk("R6 indirect t", {12'h0, t}, 16'h0000);

      // R7 STA
      clear_mem();
      mem[0] = 16'h2020; mem[1] = 16'h3040; mem[8'h20] = 16'hBEEF;
      restart();
      run_cycles(10);
      chk("R7 T4 sel", {13'h0, bus_sel}, 16'h0004);
      chk("R7 T4 bus=ac", bus, 16'hBEEF);
      run_cycles(1);
      chk("R7 stored", mem[8'h40], 16'hBEEF);
      chk("R7 pc", {4'h0, pc}, 16'h0002);
      chk("R7 t", {12'h0, t}, 16'h0000);

      // R8 BUN
      clear_mem();
      mem[0] = 16'h4123;
      restart();
      run_cycles(4);
      chk("R8 T4 sel", {13'h0, bus_sel}, 16'h0001);
      run_cycles(1);
      chk("R8 pc", {4'h0, pc}, 16'h0123);
      chk("R8 t", {12'h0, t}, 16'h0000);

      // R9 BSA
      clear_mem();
      mem[0] = 16'h5050;
      restart();
      run_cycles(6);
      chk("R9 return word", mem[8'h50], 16'h0001);
      chk("R9 pc", {4'h0, pc}, 16'h0051);
      chk("R9 t", {12'h0, t}, 16'h0000);

      // R10 ISZ sweep
      for (int k = 0; k < 4; k++) begin
         logic [15:0] v, nv;
         v = (k == 0) ? 16'hFFFF : (k == 1) ? 16'hFFFE : (k == 2) ? 16'h0000 : 16'h0005;
         nv = v + 16'h1;
         clear_mem();
         mem[0] = 16'h6060; mem[8'h60] = v;
         restart();
         run_cycles(6);
         chk("R10 T6 sel", {13'h0, bus_sel}, 16'h0003);
         run_cycles(1);
         chk("R10 written", mem[8'h60], nv);
         chk("R10 pc", {4'h0, pc}, (nv == 16'h0) ? 16'h0002 : 16'h0001);
         chk("R10 t", {12'h0, t}, 16'h0000);
      end

      // R11 opcode 7, both flavours
      for (int k = 0; k < 2; k++) begin
         clear_mem();
         mem[0] = (k == 0) ? 16'h7800 : 16'hF400;
         restart();
         run_cycles(3);
         chk("R11 reg strobe", {15'h0, rr_exec}, (k == 0) ? 16'h1 : 16'h0);
         chk("R11 dev strobe", {15'h0, io_exec}, (k == 0) ? 16'h0 : 16'h1);
         chk("R11 field", {4'h0, ext_bits}, (k == 0) ? 16'h0800 : 16'h0400);
         run_cycles(1);
         chk("R11 t", {12'h0, t}, 16'h0000);
         chk("R11 pc", {4'h0, pc}, 16'h0001);
         chk("R11 strobe gone", {14'h0, rr_exec, io_exec}, 16'h0000);
      end

      // R12 stop
      clear_mem();
      mem[0] = 16'h4000;
      restart();
      run_cycles(3);
      stop_i = 1'b1;
      run_cycles(1);
      stop_i = 1'b0;
      chk("R12 run", {15'h0, run}, 16'h0000);
      chk("R12 t frozen", {12'h0, t}, 16'h0004);
      run_cycles(20);
      chk("R12 t hold", {12'h0, t}, 16'h0004);
      chk("R12 pc hold", {4'h0, pc}, 16'h0001);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule